// File: doc/BRIEF.md
# Privilege Mode and Control Register

This block keeps track of the privilege level of a small 16-bit processor. It has two modes, kernel and user. The block supplies the four mode bits of the status word: the current mode and the mode that was active before the most recent entry into kernel. It also drives the line that selects between the two banked stack pointers. Every other register is shared between the modes and lies outside the block.

The block holds one control register on the register bus, at octal address 177700. Only kernel code may access it. The register turns address mapping on or off, plugs or unplugs the shadow boot ROM, and lets software ask for a drop to user mode. That request takes effect only when the next return-from-interrupt completes. The processor goes back to kernel mode on a software interrupt, or on an interrupt acknowledge while the user-mode hold line is low. A user-mode access to the register does not reach it. Instead it raises a one-cycle trap request that carries vector 4.

Top module: `priv_mode_ctl`

## Requirements
- R1: After reset the mode bits `psw_mode` read 4'b0000 (kernel, previous kernel), `sp_bank` is 0, `map_en` is 0, `shadow_en` is 1, and the control register reads 16'h0001.
- R2: The control register answers only at address 16'o177700. A kernel read returns bit 0 = shadow ROM enable, bit 1 = mapping enable, bit 2 = user-mode request, bit 3 = current mode (always 0), and zero in all other bits. A read at any other address returns 0, and a write at any other address changes nothing.
- R3: A kernel write to the register loads wdata[2:0] into request, mapping enable and shadow enable. The new values appear on `map_en`, `shadow_en` and on read-back in the cycle after the write.
- R4: Setting the request bit does not change the mode. The mode becomes user (`psw_mode[3:2]` = 2'b11) in the cycle after an `rti_done` strobe seen while the request is set. The request bit clears in that same cycle. `rti_done` with the request clear changes nothing.
- R5: `iack` with `iack_user_hold` low forces kernel mode (`psw_mode[3:2]` = 2'b00) in the next cycle. With the hold line high it has no effect.
- R6: `swi` forces kernel mode in the next cycle.
- R7: On every kernel entry, the previous-mode field `psw_mode[1:0]` is loaded with the mode that was current. It becomes 2'b11 on entry from user mode and 2'b00 on entry from kernel mode. Otherwise it holds its value.
- R8: `sp_bank` is 1 exactly while the current mode is user.
- R9: A read or write of the register in user mode makes `trap_req` high for exactly the next cycle, with `trap_vec` = 4. The write changes no register state. `trap_vec` is 0 when no trap is requested, and kernel accesses never trap.
- R10: When a kernel-entry event and an `rti_done` that would switch to user arrive in the same cycle, kernel entry wins and the request bit stays set.
- R11: When a kernel write and a consuming `rti_done` arrive in the same cycle, the request bit ends up 0. The write still loads mapping and shadow enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not selected) |
| rti_done | input | 1 | Return-from-interrupt (RTI or RTT) completes this cycle |
| iack | input | 1 | Interrupt acknowledge cycle |
| iack_user_hold | input | 1 | High during acknowledge keeps user mode |
| swi | input | 1 | Software interrupt executes this cycle |
| psw_mode | output | 4 | Status-word bits [15:12]: current mode, previous mode |
| sp_bank | output | 1 | Stack-pointer bank select, 1 = user |
| map_en | output | 1 | Address mapping enable |
| shadow_en | output | 1 | Shadow boot ROM enable |
| trap_req | output | 1 | Trap request pulse |
| trap_vec | output | 8 | Trap vector, 4 with a request |

## Verification
The hardest situations to reach are the ones where events collide. One is a kernel entry in the same cycle as a consuming return. Another is a write in the same cycle as a return. A third is the request state after a return, which user code cannot read back. The bench sweeps all sixteen combinations of acknowledge, hold, software interrupt and return. It runs each combination from three starting states: kernel with no request, kernel with the request set, and user. Each starting state is built from reset through the bus. Whenever a case ends in user mode, the bench forces a software interrupt to get back to kernel. It then reads the register to recover the request bit and the previous mode.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_USER   = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e cur;
        mode_e prev;
    } mode_st_t;

    typedef struct packed {
        logic req;
        logic map_en;
        logic shadow_en;
        logic trap;
    } ctl_st_t;

endpackage

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
    import priv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  iack,
    input  logic  iack_user_hold,
    input  logic  swi,
    input  logic  rti_done,
    input  logic  user_req,
    output mode_e cur_mode,
    output mode_e prev_mode,
    output logic  req_consume
);

    mode_st_t st_d, st_q;
    logic     enter_k;

    always_comb begin
        st_d        = st_q;
        enter_k     = swi | (iack & ~iack_user_hold);
        req_consume = 1'b0;
        if (enter_k) begin
            st_d.prev = st_q.cur;
            st_d.cur  = MODE_KERNEL;
        end else if (rti_done && user_req) begin
            st_d.cur    = MODE_USER;
            req_consume = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur  <= MODE_KERNEL;
            st_q.prev <= MODE_KERNEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_mode  = st_q.cur;
    assign prev_mode = st_q.prev;

    p_iack_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !iack_user_hold) |=> (cur_mode == MODE_KERNEL));

    p_swi_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swi |=> (cur_mode == MODE_KERNEL));

    p_prev_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (swi && cur_mode == MODE_USER) |=> (prev_mode == MODE_USER));

    p_entry_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (swi && rti_done) |-> !req_consume);

endmodule

// File: rtl/priv_ctl_reg.sv
module priv_ctl_reg
    import priv_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CTL_ADDR = 16'o177700,
    parameter int VEC_W    = 8,
    parameter int TRAP_VEC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  mode_e             cur_mode,
    input  logic              req_consume,
    output logic              user_req,
    output logic              map_en,
    output logic              shadow_en,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec
);

    localparam int BIT_SHADOW = 0;
    localparam int BIT_MAP    = 1;
    localparam int BIT_REQ    = 2;
    localparam int BIT_CUR    = 3;

    ctl_st_t st_d, st_q;
    logic    hit, in_kernel, kwrite;

    always_comb begin
        hit       = (bus_addr == ADDR_W'(CTL_ADDR));
        in_kernel = (cur_mode == MODE_KERNEL);
        kwrite    = hit && bus_wr && in_kernel;
        st_d      = st_q;
        st_d.trap = hit && (bus_rd || bus_wr) && !in_kernel;
        if (kwrite) begin
            st_d.req       = bus_wdata[BIT_REQ];
            st_d.map_en    = bus_wdata[BIT_MAP];
            st_d.shadow_en = bus_wdata[BIT_SHADOW];
        end
        if (req_consume) begin
            st_d.req = 1'b0;
        end
        bus_rdata = '0;
        if (hit && bus_rd && in_kernel) begin
            bus_rdata[BIT_SHADOW] = st_q.shadow_en;
            bus_rdata[BIT_MAP]    = st_q.map_en;
            bus_rdata[BIT_REQ]    = st_q.req;
            bus_rdata[BIT_CUR]    = cur_mode[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req       <= 1'b0;
            st_q.map_en    <= 1'b0;
            st_q.shadow_en <= 1'b1;
            st_q.trap      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign user_req  = st_q.req;
    assign map_en    = st_q.map_en;
    assign shadow_en = st_q.shadow_en;
    assign trap_req  = st_q.trap;
    assign trap_vec  = st_q.trap ? VEC_W'(TRAP_VEC) : '0;

    p_user_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (bus_rd || bus_wr) && cur_mode == MODE_USER) |=> trap_req);

    p_user_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cur_mode == MODE_USER && !req_consume)
        |=> ($stable(map_en) && $stable(shadow_en) && $stable(user_req)));

    p_consume_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_consume |=> !user_req);

endmodule

// File: rtl/priv_mode_ctl.sv
module priv_mode_ctl
    import priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rti_done,
    input  logic        iack,
    input  logic        iack_user_hold,
    input  logic        swi,
    output logic [3:0]  psw_mode,
    output logic        sp_bank,
    output logic        map_en,
    output logic        shadow_en,
    output logic        trap_req,
    output logic [7:0]  trap_vec
);

    mode_e cur_mode, prev_mode;
    logic  req_consume, user_req;

    priv_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .iack           (iack),
        .iack_user_hold (iack_user_hold),
        .swi            (swi),
        .rti_done       (rti_done),
        .user_req       (user_req),
        .cur_mode       (cur_mode),
        .prev_mode      (prev_mode),
        .req_consume    (req_consume)
    );

    priv_ctl_reg #(
        .ADDR_W   (16),
        .DATA_W   (16),
        .CTL_ADDR (16'o177700),
        .VEC_W    (8),
        .TRAP_VEC (4)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cur_mode    (cur_mode),
        .req_consume (req_consume),
        .user_req    (user_req),
        .map_en      (map_en),
        .shadow_en   (shadow_en),
        .trap_req    (trap_req),
        .trap_vec    (trap_vec)
    );

    assign psw_mode = {cur_mode, prev_mode};
    assign sp_bank  = (cur_mode == MODE_USER);

    p_user_entry_req_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_mode == MODE_USER) |-> !user_req);

    p_rti_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_done && !user_req && cur_mode == MODE_KERNEL) |=> (cur_mode == MODE_KERNEL));

endmodule

// File: tb/sim_priv_mode_ctl.sv
module sim_priv_mode_ctl;

    localparam logic [15:0] CTL = 16'o177700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rti_done = 1'b0, iack = 1'b0, iack_user_hold = 1'b0, swi = 1'b0;
    logic [3:0]  psw_mode;
    logic        sp_bank, map_en, shadow_en, trap_req;
    logic [7:0]  trap_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    priv_mode_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rti_done(rti_done), .iack(iack), .iack_user_hold(iack_user_hold),
        .swi(swi), .psw_mode(psw_mode), .sp_bank(sp_bank), .map_en(map_en),
        .shadow_en(shadow_en), .trap_req(trap_req), .trap_vec(trap_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr_at(input logic [15:0] a, input logic [15:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd_at(input logic [15:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
        #1;
    endtask

    task automatic go_user();
        wr_at(CTL, 16'h0004);
        rti_done = 1'b1;
        tick();
        rti_done = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        do_reset();
        // R1 reset state
        chk("R1 psw_mode", psw_mode, 4'b0000);
        chk("R1 sp_bank", sp_bank, 0);
        chk("R1 map_en", map_en, 0);
        chk("R1 shadow_en", shadow_en, 1);
        chk("R1 trap_req", trap_req, 0);
        rd_at(CTL, rv);
        chk("R1 readback", rv, 16'h0001);

        // R3 and R2: sweep all three writable bits in kernel mode
        for (int v = 0; v < 8; v++) begin
            wr_at(CTL, 16'(v) | 16'hFFF8);
            chk("R3 map_en", map_en, (v >> 1) & 1);
            chk("R3 shadow_en", shadow_en, v & 1);
            rd_at(CTL, rv);
            chk("R2 R3 readback layout", rv, v);
            chk("R9 kernel no trap", trap_req, 0);
        end

        // R2 neighbouring addresses neither answer nor take writes
        wr_at(CTL, 16'h0002);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a;
            a = CTL ^ (16'h1 << k);
            rd_at(a, rv);
            chk("R2 other addr read", rv, 0);
            wr_at(a, 16'h0005);
            rd_at(CTL, rv);
            chk("R2 other addr write", rv, 16'h0002);
        end

        // R9 user-mode access traps and changes nothing
        do_reset();
        wr_at(CTL, 16'h0006);
        rti_done = 1'b1; tick(); rti_done = 1'b0;
        chk("R4 user mode", psw_mode, 4'b1100);
        chk("R8 sp_bank user", sp_bank, 1);
        chk("R9 no trap idle", trap_vec, 0);
        wr_at(CTL, 16'h0005);
        chk("R9 trap on write", trap_req, 1);
        chk("R9 vector", trap_vec, 4);
        chk("R9 map unchanged", map_en, 1);
        chk("R9 shadow unchanged", shadow_en, 0);
        tick();
        chk("R9 trap one cycle", trap_req, 0);
        chk("R9 vector idle", trap_vec, 0);
        bus_addr = CTL; bus_rd = 1'b1;
        #1 chk("R9 user read data", bus_rdata, 0);
        tick();
        bus_rd = 1'b0; bus_addr = '0;
        chk("R9 trap on read", trap_req, 1);
        chk("R9 read vector", trap_vec, 4);
        swi = 1'b1; tick(); swi = 1'b0;
        chk("R6 R7 back to kernel", psw_mode, 4'b0011);
        rd_at(CTL, rv);
        chk("R9 state after trapped write", rv, 16'h0002);

        // R11 write collides with consuming return
        do_reset();
        wr_at(CTL, 16'h0004);
        bus_addr = CTL; bus_wr = 1'b1; bus_wdata = 16'h0007; rti_done = 1'b1;
        tick();
        bus_wr = 1'b0; rti_done = 1'b0; bus_addr = '0;
        chk("R11 user after collision", psw_mode[3:2], 2'b11);
        chk("R11 map loaded", map_en, 1);
        chk("R11 shadow loaded", shadow_en, 1);
        swi = 1'b1; tick(); swi = 1'b0;
        rd_at(CTL, rv);
        chk("R11 req cleared", rv, 16'h0003);

        // R4..R8, R10: all event combinations from three start states
        for (int st = 0; st < 3; st++) begin
            for (int ev = 0; ev < 16; ev++) begin
                logic [1:0] cur, prev, ecur, eprev;
                logic       req, ereq, ent, rti;
                logic [15:0] base;
                do_reset();
                if (st >= 1) wr_at(CTL, 16'h0004);
                if (st == 2) begin rti_done = 1'b1; tick(); rti_done = 1'b0; end
                cur  = (st == 2) ? 2'b11 : 2'b00;
                prev = 2'b00;
                req  = (st == 1);
                base = (st == 0) ? 16'h0001 : 16'h0000;
                iack = ev[0]; iack_user_hold = ev[1]; swi = ev[2]; rti_done = ev[3];
                tick();
                iack = 0; iack_user_hold = 0; swi = 0; rti_done = 0;
                ent = (ev[0] && !ev[1]) || ev[2];
                rti = ev[3];
                ecur = cur; eprev = prev; ereq = req;
                if (ent) begin
                    eprev = cur; ecur = 2'b00;
                end else if (rti && req) begin
                    ecur = 2'b11; ereq = 1'b0;
                end
                chk("R4 R5 R6 R7 R10 psw_mode", psw_mode, {ecur, eprev});
                chk("R8 sp_bank", sp_bank, ecur[0]);
                if (ecur == 2'b11) begin
                    swi = 1'b1; tick(); swi = 1'b0;
                    chk("R7 prev after entry", psw_mode, 4'b0011);
                end
                rd_at(CTL, rv);
                chk("R4 R10 req bit", rv, base | (16'(ereq) << 2));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule